// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a periodic down-counter of the kind a processor uses as its operating-system heartbeat. Software reaches it through four 32-bit word registers: control, reload value, current value and a read-only calibration word. Once enabled, a 24-bit counter decrements once per tick. A tick is either every core-clock cycle or every rising edge of a slower, asynchronous reference clock. When the counter is at zero it reloads on the next tick. Each time it steps from one to zero, a sticky count flag is set and, if enabled, a one-cycle interrupt request pulse is issued.

The register port is a simple strobed access: one access per core-clock cycle, selected by a two-bit word index (word 0 at byte offset 0x0, word 1 at 0x4, word 2 at 0x8, word 3 at 0xC). Read data is combinational from the current register state. Writes and the side effects of a read take hold at the closing clock edge. The access is always accepted, so the port has no back-pressure. The calibration word reports, from parameters, whether a reference clock exists, whether its 10 ms count is inexact, and how many reference ticks make 10 ms.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset, control, reload and current read 0 and the interrupt request is low.
- R2: Word 0 (control) holds the enable in bit 0, the interrupt enable in bit 1, the tick source in bit 2 (1 = core clock, 0 = reference clock) and the count flag in bit 16. Its other bits read 0. Word 1 is reload, word 2 is current and word 3 is calibration.
- R3: While enabled, the counter decreases by one on each tick. While disabled, or with no tick, it holds its value.
- R4: A tick that arrives with the counter at 0 loads the reload value instead of decrementing. With a reload of 0 the counter stays at 0 and never sets the flag.
- R5: A write of any data to word 2 clears the counter to 0 and clears the count flag. In the same cycle it overrides a tick, so no 1-to-0 event occurs.
- R6: The count flag is set by each 1-to-0 step of the counter. A read of word 0 returns the flag's value and then clears it. If that read falls in the same cycle as a 1-to-0 step, the flag stays set.
- R7: With the interrupt enable set, the request is high for exactly the one core-clock cycle that follows each 1-to-0 step.
- R8: With the reference source selected, the counter moves once per rising edge of the reference clock, seen through a two-flop synchronizer, and not at all while that clock is steady. The reference frequency must be at most half the core frequency.
- R9: Bits 31:24 of writes to words 1 and 2 are ignored, and those bits read 0.
- R10: Word 3 reads {NOREF, SKEW, 6'b0, TENMS[23:0]} from parameters, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk | input | 1 | Asynchronous slow reference clock |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_word | input | 2 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is a control read, which clears the flag, and the counter's 1-to-0 step, which sets it. The bench provokes this by reading control every third cycle of each reload sweep, so for several reload values the read lands on the wrap edge. It then requires the next control read to still show the flag. The second pair is a clear-write to the current word and a tick that would have wrapped. The bench issues the write exactly when the counter holds 1 and judges that the counter reads 0 with no flag set and no interrupt pulse.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned REG_W = 32;

  // word indices on the register port
  localparam logic [1:0] W_CTRL   = 2'd0;
  localparam logic [1:0] W_RELOAD = 2'd1;
  localparam logic [1:0] W_CUR    = 2'd2;
  localparam logic [1:0] W_CALIB  = 2'd3;

  // control word bit positions
  localparam int unsigned C_EN    = 0;
  localparam int unsigned C_INTEN = 1;
  localparam int unsigned C_SRC   = 2;
  localparam int unsigned C_FLAG  = 16;

  // calibration word bit positions
  localparam int unsigned K_NOREF = 31;
  localparam int unsigned K_SKEW  = 30;
endpackage

// File: rtl/systick_ref_sync.sv
module systick_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic ref_rise
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= ref_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // edge is detected between the last synchronizer stage and one extra history flop
  assign ref_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  AST_REF_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise); // R8
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (tick)    cnt_q <= at_zero ? reload : cnt_q - ONE;
  end

  // clear has priority over a tick, so no wrap event can coincide with it
  assign wrap  = tick & ~clear & (cnt_q == ONE);
  assign count = cnt_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0)); // R5
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count != '0) |=> (count == $past(count) - ONE)); // R3
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count == '0) |=> (count == $past(reload))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> $stable(count)); // R3
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W   = 24,
  parameter logic [23:0] TENMS   = 24'd0,
  parameter bit          NOREF   = 1'b0,
  parameter bit          SKEW    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [1:0]       reg_word,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0] count,
  input  logic             wrap,
  output logic             cfg_en,
  output logic             cfg_src,
  output logic [CNT_W-1:0] cfg_reload,
  output logic             clear,
  output logic             irq
);
  localparam int unsigned PAD = REG_W - CNT_W;

  logic wr_acc, rd_acc;
  logic en_q, inten_q, src_q, flag_q, irq_q;
  logic [CNT_W-1:0] reload_q;
  logic [REG_W-1:0] ctrl_word, calib_word;

  assign wr_acc = reg_en & reg_we;
  assign rd_acc = reg_en & ~reg_we;
  assign clear  = wr_acc & (reg_word == W_CUR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      inten_q <= 1'b0;
      src_q   <= 1'b0;
    end else if (wr_acc && reg_word == W_CTRL) begin
      en_q    <= reg_wdata[C_EN];
      inten_q <= reg_wdata[C_INTEN];
      src_q   <= reg_wdata[C_SRC];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                reload_q <= '0;
    else if (wr_acc && reg_word == W_RELOAD)   reload_q <= reg_wdata[CNT_W-1:0];
  end

  // a wrap in the same cycle as a clearing access wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)                                          flag_q <= 1'b0;
    else if (wrap)                                       flag_q <= 1'b1;
    else if ((rd_acc && reg_word == W_CTRL) || clear)    flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap & inten_q;
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[C_EN]    = en_q;
    ctrl_word[C_INTEN] = inten_q;
    ctrl_word[C_SRC]   = src_q;
    ctrl_word[C_FLAG]  = flag_q;
  end

  always_comb begin
    calib_word          = '0;
    calib_word[23:0]    = TENMS;
    calib_word[K_SKEW]  = SKEW;
    calib_word[K_NOREF] = NOREF;
  end

  always_comb begin
    unique case (reg_word)
      W_CTRL:   reg_rdata = ctrl_word;
      W_RELOAD: reg_rdata = {{PAD{1'b0}}, reload_q};
      W_CUR:    reg_rdata = {{PAD{1'b0}}, count};
      default:  reg_rdata = calib_word;
    endcase
  end

  assign cfg_en     = en_q;
  assign cfg_src    = src_q;
  assign cfg_reload = reload_q;
  assign irq        = irq_q;

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wrap)); // R7
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [23:0] TENMS       = 24'd0,
  parameter bit          NOREF       = 1'b0,
  parameter bit          SKEW        = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_clk,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [1:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic             ref_rise, tick, clear, wrap, cfg_en, cfg_src;
  logic [CNT_W-1:0] cfg_reload, count;

  systick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_async (ref_clk),
    .ref_rise  (ref_rise)
  );

  assign tick = cfg_en & (cfg_src | ref_rise);

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clear  (clear),
    .reload (cfg_reload),
    .count  (count),
    .wrap   (wrap)
  );

  systick_regs #(
    .CNT_W (CNT_W),
    .TENMS (TENMS),
    .NOREF (NOREF),
    .SKEW  (SKEW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_word   (reg_word),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .count      (count),
    .wrap       (wrap),
    .cfg_en     (cfg_en),
    .cfg_src    (cfg_src),
    .cfg_reload (cfg_reload),
    .clear      (clear),
    .irq        (irq)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word == W_RELOAD || reg_word == W_CUR) |-> (reg_rdata[31:CNT_W] == '0)); // R9
endmodule

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam logic [23:0] TENMS = 24'd1000;
  localparam logic [31:0] CAL   = 32'h4000_03E8;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_word = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  bit m_en, m_inten, m_src, m_flag, m_irq;
  logic [23:0] m_reload, m_cnt;

  always #10 clk = ~clk;

  sys_tick_timer #(.TENMS(TENMS), .NOREF(1'b0), .SKEW(1'b1)) i_sys_tick_timer (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .reg_en(reg_en), .reg_we(reg_we),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [1:0] w);
    case (w)
      2'd0:    return {15'b0, m_flag, 13'b0, m_src, m_inten, m_en};
      2'd1:    return {8'b0, m_reload};
      2'd2:    return {8'b0, m_cnt};
      default: return CAL;
    endcase
  endfunction

  // one bus cycle: drive at the falling edge, check, then advance the model at the rising edge
  task automatic cyc(input bit en, input bit we, input logic [1:0] w, input logic [31:0] d,
                     input string req);
    bit tk, wr_cur, rd_ctl, wr_ev;
    @(negedge clk);
    reg_en = en; reg_we = we; reg_word = w; reg_wdata = d;
    #1;
    if (en && !we) check(reg_rdata, exp_word(w), req);
    check({31'b0, irq}, {31'b0, m_irq}, "R7");
    @(posedge clk);
    tk     = m_en && m_src;
    wr_cur = en && we && w == 2'd2;
    rd_ctl = en && !we && w == 2'd0;
    wr_ev  = tk && m_cnt == 24'd1 && !wr_cur;
    m_irq  = wr_ev && m_inten;
    if (wr_cur)  m_cnt = '0;
    else if (tk) m_cnt = (m_cnt == '0) ? m_reload : m_cnt - 24'd1;
    if (wr_ev) m_flag = 1'b1;
    else if (rd_ctl || wr_cur) m_flag = 1'b0;
    if (en && we && w == 2'd0) begin m_en = d[0]; m_inten = d[1]; m_src = d[2]; end
    if (en && we && w == 2'd1) m_reload = d[23:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, '0, "R3");
  endtask

  initial begin
    m_en = 0; m_inten = 0; m_src = 0; m_flag = 0; m_irq = 0; m_reload = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values, R10 calibration word
    cyc(1, 0, 2'd0, '0, "R1");
    cyc(1, 0, 2'd1, '0, "R1");
    cyc(1, 0, 2'd2, '0, "R1");
    cyc(1, 0, 2'd3, '0, "R10");

    // R9 upper bits of reload and current are dropped
    cyc(1, 1, 2'd1, 32'hFF00_0005, "R9");
    cyc(1, 0, 2'd1, '0, "R9");
    cyc(1, 1, 2'd2, 32'hFFFF_FFFF, "R9");
    cyc(1, 0, 2'd2, '0, "R5");
    // R10 calibration ignores writes
    cyc(1, 1, 2'd3, 32'h1234_5678, "R10");
    cyc(1, 0, 2'd3, '0, "R10");
    // R2 unused control bits read 0
    cyc(1, 1, 2'd0, 32'hFFFE_FFF8, "R2");
    cyc(1, 0, 2'd0, '0, "R2");
    // R3 disabled counter holds
    idle(4);
    cyc(1, 0, 2'd2, '0, "R3");

    // sweep reload 0..6 on the core clock; control read every third cycle (R6 collisions)
    for (int L = 0; L <= 6; L++) begin
      cyc(1, 1, 2'd1, L, "R4");
      cyc(1, 1, 2'd2, '0, "R5");
      cyc(1, 1, 2'd0, 32'h5 | ((L % 2) << 1), "R2");
      for (int k = 0; k < 3 * (L + 2) + 4; k++) begin
        if (k % 3 == 2) cyc(1, 0, 2'd0, '0, "R6");
        else            cyc(1, 0, 2'd2, '0, (L == 0) ? "R4" : "R3");
      end
      cyc(1, 1, 2'd0, '0, "R2");
      cyc(1, 0, 2'd0, '0, "R6");
      cyc(1, 0, 2'd0, '0, "R6");
    end

    // R5 clear-write landing when the counter holds 1
    cyc(1, 1, 2'd1, 32'd4, "R5");
    cyc(1, 1, 2'd0, 32'h7, "R5");
    for (int k = 0; k < 30; k++) begin
      if (m_cnt == 24'd1 && m_en) cyc(1, 1, 2'd2, 32'hDEAD_BEEF, "R5");
      else                        cyc(1, 0, 2'd2, '0, "R5");
    end
    cyc(1, 0, 2'd0, '0, "R5");
    cyc(1, 1, 2'd0, '0, "R5");

    // R8 reference source: first rise loads 10, then three decrements
    cyc(1, 1, 2'd1, 32'd10, "R8");
    cyc(1, 1, 2'd2, '0, "R8");
    cyc(1, 1, 2'd0, 32'h1, "R8");
    idle(6);
    cyc(1, 0, 2'd2, '0, "R8");
    for (int r = 0; r < 4; r++) begin
      ref_clk = 1'b1; idle(4);
      ref_clk = 1'b0; idle(4);
    end
    idle(2);
    m_cnt = 24'd7;
    cyc(1, 0, 2'd2, '0, "R8");
    idle(8);
    cyc(1, 0, 2'd2, '0, "R8");
    cyc(1, 0, 2'd0, '0, "R8");
    idle(1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule